// File: doc/BRIEF.md
# Flash Busy Status Poller

This block forms the byte returned to a host read while a flash device's internal program or erase engine is running. When the engine is idle, reads pass the array data through unchanged. While it is busy, the byte carries status instead of data. The top bit tells the host what completion will look like. The next bit alternates on every separate read access. This lets software detect the end of an operation in either of two ways: it can poll until the top bit matches what it wrote, or it can read twice and see the alternating bit stop moving.

A read access is marked by the read-enable input. A new access begins when that input goes from low to high. Holding it high, or changing the address, is still the same access. All inputs are sampled on the rising clock edge, and the read value is registered, so it appears one cycle after the inputs that produce it.

Top module: `flash_busy_poller`

## Requirements
- R1: While `busy` is 1 and `op_erase` is 0 (program), bit 7 of `rd_data` equals the inverse of bit 7 of `load_byte`.
- R2: While `busy` is 0, all eight bits of `rd_data` equal `array_data`, one clock after it was sampled.
- R3: While `busy` is 1, each low-to-high transition of `rd_en` inverts bit 6 of `rd_data`, starting from the edge at which the transition is sampled.
- R4: While `busy` stays 1 and `rd_en` shows no new low-to-high transition, bit 6 of `rd_data` holds its value. This applies both when `rd_en` is held high and when `array_data` changes.
- R5: While `busy` is 1 and `op_erase` is 1, bit 7 of `rd_data` is 0.
- R6: While `busy` is 1, bits 5 down to 0 of `rd_data` are 0.
- R7: When `busy` rises, the alternating bit restarts. Before the first access of the operation, bit 6 reads 0. The first access reads 1, the second reads 0, and so on. An access that begins in the same cycle that `busy` rises counts as the first.
- R8: While `rst` is 1, and on the first cycle after it, `rd_data` is 0 and the alternating bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy | input | 1 | Internal program or erase in progress |
| op_erase | input | 1 | 1 = running operation is an erase, 0 = program |
| load_byte | input | 8 | Last byte loaded for programming |
| rd_en | input | 1 | Read access active; a rising transition starts a new access |
| array_data | input | 8 | True array contents at the read address |
| rd_data | output | 8 | Value presented to the host read |

## Verification
All results are due exactly one clock after the inputs that cause them. Each input set is driven on a falling clock edge and captured on the next rising edge, and `rd_data` is compared at the following falling edge. The bench keeps its own model of the previous `rd_en` and `busy` levels and of the alternating bit. It sweeps every value of `load_byte` under both program and erase, with several read accesses per operation. Some accesses are held high across several cycles, and one starts in the same cycle as `busy` rises. Bit 7, bit 6 and the low bits are each checked separately after every step.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
    localparam int DATA_W     = 8;
    localparam int POLL_BIT   = 7;
    localparam int TOGGLE_BIT = 6;

    typedef struct packed {
        logic poll;
        logic toggle;
    } status_t;

    function automatic logic [DATA_W-1:0] pack_status(input status_t s);
        logic [DATA_W-1:0] v;
        v = '0;
        v[POLL_BIT]   = s.poll;
        v[TOGGLE_BIT] = s.toggle;
        return v;
    endfunction

    function automatic logic poll_value(input logic erase, input logic load_msb);
        return erase ? 1'b0 : ~load_msb;
    endfunction
endpackage

// File: rtl/fbp_access_edge.sv
module fbp_access_edge (
    input  logic clk,
    input  logic rst,
    input  logic rd_en,
    output logic new_access
);
    logic rd_prev;

    always_ff @(posedge clk) begin
        if (rst) rd_prev <= 1'b0;
        else     rd_prev <= rd_en;
    end

    assign new_access = rd_en & ~rd_prev;
endmodule

// File: rtl/fbp_toggle_track.sv
module fbp_toggle_track (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic new_access,
    output logic tog_next,
    output logic tog_q
);
    logic busy_prev;

    always_comb begin
        tog_next = tog_q;
        if (busy && !busy_prev)   tog_next = new_access;
        else if (busy && new_access) tog_next = ~tog_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tog_q     <= 1'b0;
            busy_prev <= 1'b0;
        end else begin
            tog_q     <= tog_next;
            busy_prev <= busy;
        end
    end

    // R3: a new access within a running operation inverts the state
    p_flip_on_access_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && busy_prev && new_access) |=> (tog_q != $past(tog_q)));

    // R4: no new access keeps the state
    p_hold_no_access_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && busy_prev && !new_access) |=> $stable(tog_q));

    // R7: start of an operation restarts the sequence
    p_restart_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && !busy_prev) |=> (tog_q == $past(new_access)));
endmodule

// File: rtl/fbp_read_mux.sv
module fbp_read_mux
    import flash_poll_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              op_erase,
    input  logic              load_msb,
    input  logic              tog_next,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_q
);
    status_t st;

    always_comb begin
        st.poll   = poll_value(op_erase, load_msb);
        st.toggle = tog_next;
    end

    always_ff @(posedge clk) begin
        if (rst)       rd_q <= '0;
        else if (busy) rd_q <= pack_status(st);
        else           rd_q <= array_data;
    end
endmodule

// File: rtl/flash_busy_poller.sv
module flash_busy_poller
    import flash_poll_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              op_erase,
    input  logic [DATA_W-1:0] load_byte,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data
);
    logic new_access;
    logic tog_next;
    logic tog_q;

    fbp_access_edge u_edge (
        .clk        (clk),
        .rst        (rst),
        .rd_en      (rd_en),
        .new_access (new_access)
    );

    fbp_toggle_track u_track (
        .clk        (clk),
        .rst        (rst),
        .busy       (busy),
        .new_access (new_access),
        .tog_next   (tog_next),
        .tog_q      (tog_q)
    );

    fbp_read_mux u_mux (
        .clk        (clk),
        .rst        (rst),
        .busy       (busy),
        .op_erase   (op_erase),
        .load_msb   (load_byte[POLL_BIT]),
        .tog_next   (tog_next),
        .array_data (array_data),
        .rd_q       (rd_data)
    );

    p_prog_poll_r1: assert property (@(posedge clk) disable iff (rst)
        (busy && !op_erase) |=> (rd_data[POLL_BIT] == !$past(load_byte[POLL_BIT])));

    p_idle_pass_r2: assert property (@(posedge clk) disable iff (rst)
        !busy |=> (rd_data == $past(array_data)));

    p_erase_poll_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && op_erase) |=> (rd_data[POLL_BIT] == 1'b0));

    p_low_zero_r6: assert property (@(posedge clk) disable iff (rst)
        busy |=> (rd_data[TOGGLE_BIT-1:0] == '0));

    p_bit6_tracks_r3: assert property (@(posedge clk) disable iff (rst)
        busy |=> (rd_data[TOGGLE_BIT] == tog_q));

    p_reset_clear_r8: assert property (@(posedge clk)
        rst |=> (rd_data == '0));
endmodule

// File: tb/test_flash_busy_poller.sv
module test_flash_busy_poller;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst;
    logic       busy;
    logic       op_erase;
    logic [7:0] load_byte;
    logic       rd_en;
    logic [7:0] array_data;
    logic [7:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;

    logic m_prev_rd   = 1'b0;
    logic m_prev_busy = 1'b0;
    logic m_tog       = 1'b0;
    bit   done        = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_busy_poller i_flash_busy_poller (
        .clk        (clk),
        .rst        (rst),
        .busy       (busy),
        .op_erase   (op_erase),
        .load_byte  (load_byte),
        .rd_en      (rd_en),
        .array_data (array_data),
        .rd_data    (rd_data)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive at a falling edge, let the rising edge capture, compare at the next falling edge.
    task automatic step(input logic b, input logic er, input logic [7:0] ld,
                        input logic rd, input logic [7:0] arr);
        logic       rise;
        logic [7:0] exp;
        busy = b; op_erase = er; load_byte = ld; rd_en = rd; array_data = arr;
        rise = rd && !m_prev_rd;
        if (b && !m_prev_busy)  m_tog = rise;     // R7 restart
        else if (b && rise)     m_tog = ~m_tog;   // R3 flip, R4 hold otherwise
        m_prev_rd   = rd;
        m_prev_busy = b;
        exp = b ? {(er ? 1'b0 : ~ld[7]), m_tog, 6'b0} : arr;
        @(negedge clk);
        if (!b) begin
            check("R2 idle data", rd_data, exp);
        end else begin
            check(er ? "R5 erase bit7" : "R1 program bit7", {7'b0, rd_data[7]}, {7'b0, exp[7]});
            check("R3 R4 R7 bit6", {7'b0, rd_data[6]}, {7'b0, exp[6]});
            check("R6 low bits", {2'b0, rd_data[5:0]}, 8'h00);
        end
    endtask

    initial begin
        rst = 1'b1; busy = 1'b0; op_erase = 1'b0; load_byte = 8'h00;
        rd_en = 1'b0; array_data = 8'hA5;
        @(negedge clk);
        check("R8 reset value", rd_data, 8'h00);
        @(negedge clk);
        rst = 1'b0;
        m_prev_rd = 1'b0; m_prev_busy = 1'b0; m_tog = 1'b0;
        step(1'b0, 1'b0, 8'h00, 1'b0, 8'h3C);
        for (int ld = 0; ld < 256; ld++) begin
            for (int er = 0; er < 2; er++) begin
                logic [7:0] a;
                a = 8'(ld) ^ 8'h5A;
                // odd loads start an access in the same cycle busy rises (R7)
                step(1'b1, er[0], 8'(ld), ld[0], a);
                step(1'b1, er[0], 8'(ld), ld[0], ~a);
                for (int k = 0; k < 3; k++) begin
                    step(1'b1, er[0], 8'(ld), 1'b0, a + 8'(k));
                    step(1'b1, er[0], 8'(ld), 1'b1, a + 8'(k));
                    step(1'b1, er[0], 8'(ld), 1'b1, a - 8'(k)); // R4 held access
                end
                step(1'b0, er[0], 8'(ld), 1'b0, a);   // R2 on completion
                step(1'b0, er[0], 8'(ld), 1'b1, ~a);
                step(1'b0, er[0], 8'(ld), 1'b0, a ^ 8'hFF);
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule